// File: doc/BRIEF.md
# SoC Global Control Register Bank

This block holds the chip's global control and status words behind a small 32-bit register-bus slave. It decodes a 4 KiB window, and only its lowest 82 words (byte offsets 0x000 to 0x144) are backed by storage. Each backed word follows one of four update rules: it stores whatever is written, it ignores writes, a one in the write data clears that bit, or a one in the write data sets that bit. The block only stores and returns values. It drives no pin muxing, memory controller, USB or processor-boot logic.

A cold reset loads the full reset image. Most of that image is fixed constants, and every word without a constant reads zero. Two words are taken from input pins at reset: a power-on strap word and a mask of disabled modules. One word carries a field that encodes the DRAM size, and that size is fixed by an elaboration parameter. The parameter must be a power of two from 128 to 2048 MiB, and any other value stops elaboration. A warm reset request clears only the bus response state, so software-visible contents survive it.

Every access gets its response one cycle later. There are no wait states. Bad accesses are flagged rather than stalled.

Top module: `sysctl_regbank`

## Requirements
- R1: On cold reset every backed word reads zero except these: 0x000=0x04A92750, 0x014=0x0000FFFF, 0x038=0x00000003, 0x03C=0x0000035E, 0x050=0x0000004E, 0x060=0x00080000, 0x06C=0x80000000, 0x078=0x000000C0, 0x098=0x5A00F3CF, 0x13C=0x00000008, 0x140=0x034730E4, 0x144=0x034730E4, plus the words given in R2 and R3.
- R2: On cold reset, word 0x004 takes the value of `strapIn` and word 0x07C takes the value of `modDisIn`.
- R3: On cold reset, word 0x09C takes 0x00001002 ORed with (log2(DRAM_MB/128) << 8). With the default DRAM_MB=512 this gives 0x00001202.
- R4: A valid write to any backed word not named in R5 to R7 stores the write data unchanged.
- R5: Words 0x000, 0x004 and 0x040 are read-only, and writes to them leave their contents unchanged.
- R6: Words 0x06C and 0x0D4 are write-one-to-clear: new = old AND NOT data.
- R7: Words 0x070 and 0x07C are write-one-to-set: new = old OR data. Software cannot clear their bits.
- R8: An access at byte offset 0x148 or above reads zero, changes no word, and raises `busErr`.
- R9: An access with `busAddr[1:0]` not equal to 0, or with `busByteEn` not equal to 4'b1111, raises `busErr`, returns zero and changes no word.
- R10: Each request taken while `warmRst` is low produces `busReady` high for exactly the next cycle, with `busErr` valid in that same cycle. `busReady` is low in every other cycle.
- R11: While `warmRst` is high, requests are dropped: they get no ready and make no change. Register contents are unchanged across a warm reset.
- R12: `busRdata` is zero in every cycle that does not complete a valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRst | input | 1 | Synchronous active-high cold reset; loads the reset image |
| warmRst | input | 1 | Warm reset request; clears bus response state only |
| busReq | input | 1 | Access request, one cycle per access |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte offset in the 4 KiB window |
| busByteEn | input | 4 | Byte lanes; only 4'b1111 is a valid access |
| busWdata | input | 32 | Write data, little-endian |
| busRdata | output | 32 | Read data, registered |
| busReady | output | 1 | Response strobe, one cycle after a request |
| busErr | output | 1 | Bad-access flag, valid with busReady |
| strapIn | input | 32 | Power-on strap word sampled at cold reset |
| modDisIn | input | 32 | Disabled-module mask sampled at cold reset |

## Verification
Register updates and all three response outputs come from flops clocked by the same edge that samples the request. A request driven before edge N therefore shows its ready, error flag and read data after edge N. A read issued in the following cycle returns the word as updated by the earlier write. The bench drives each request for a single cycle starting at a falling edge and samples the outputs at the next falling edge. Requests are back to back, so a read that follows a write in the vector table checks the write rule with no idle gap. Warm- and cold-reset checks sample only after the reset input has been released and a fresh read has completed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned REG_COUNT  = 82;
  localparam int unsigned IDX_W      = $clog2(REG_COUNT);
  localparam int unsigned LANES      = WORD_W / 8;

  // word indices whose reset value is not a fixed constant
  localparam int unsigned STRAP_IDX  = 1;   // 0x004
  localparam int unsigned MODDIS_IDX = 31;  // 0x07C
  localparam int unsigned MEMCFG_IDX = 39;  // 0x09C

  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_W1C = 2'd2,
    ACC_W1S = 2'd3
  } accRuleT;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [IDX_W-1:0] idx;
  } bankStrobeT;

  function automatic accRuleT ruleOf(int unsigned idx);
    case (idx)
      0, 1, 16: ruleOf = ACC_RO;   // 0x000, 0x004, 0x040
      27, 53:   ruleOf = ACC_W1C;  // 0x06C, 0x0D4
      28, 31:   ruleOf = ACC_W1S;  // 0x070, 0x07C
      default:  ruleOf = ACC_RW;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] fixedResetOf(int unsigned idx);
    case (idx)
      0:       fixedResetOf = 32'h04A9_2750;
      5:       fixedResetOf = 32'h0000_FFFF;
      14:      fixedResetOf = 32'h0000_0003;
      15:      fixedResetOf = 32'h0000_035E;
      20:      fixedResetOf = 32'h0000_004E;
      24:      fixedResetOf = 32'h0008_0000;
      27:      fixedResetOf = 32'h8000_0000;
      30:      fixedResetOf = 32'h0000_00C0;
      38:      fixedResetOf = 32'h5A00_F3CF;
      79:      fixedResetOf = 32'h0000_0008;
      80, 81:  fixedResetOf = 32'h0347_30E4;
      default: fixedResetOf = '0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              coldRst,
  input  logic              warmRst,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [LANES-1:0]  busByteEn,
  output bankStrobeT        stb,
  output logic              busReady,
  output logic              busErr
);

  localparam int unsigned BACKED_BYTES = REG_COUNT * LANES;
  localparam int unsigned ALIGN_W      = $clog2(LANES);

  logic taken;
  logic aligned;
  logic fullWidth;
  logic inRange;
  logic accessOk;

  always_comb begin
    taken     = busReq && !warmRst;
    aligned   = (busAddr[ALIGN_W-1:0] == '0);
    fullWidth = (busByteEn == '1);
    inRange   = (busAddr < ADDR_W'(BACKED_BYTES));
    accessOk  = taken && aligned && fullWidth && inRange;
    stb.rd    = accessOk && !busWe;
    stb.wr    = accessOk && busWe;
    stb.idx   = busAddr[IDX_W+ALIGN_W-1:ALIGN_W];
  end

  always_ff @(posedge clk) begin
    if (coldRst || warmRst) begin
      busReady <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      busReady <= taken;
      busErr   <= taken && !accessOk;
    end
  end

endmodule

// File: rtl/sysctl_dpath.sv
module sysctl_dpath
  import sysctl_pkg::*;
#(
  parameter int unsigned DRAM_MB = 512
) (
  input  logic              clk,
  input  logic              coldRst,
  input  logic              warmRst,
  input  bankStrobeT        stb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] strapIn,
  input  logic [WORD_W-1:0] modDisIn,
  output logic [WORD_W-1:0] busRdata
);

  localparam int unsigned DRAM_LOG   = $clog2(DRAM_MB / 128);
  localparam logic [WORD_W-1:0] MEMCFG_RST =
    WORD_W'(32'h0000_1002) | (WORD_W'(DRAM_LOG) << 8);

  logic [WORD_W-1:0] word [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam accRuleT RULE = ruleOf(i);
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] rstVal;
    logic              hit;

    if (i == STRAP_IDX) begin : g_strap
      assign rstVal = strapIn;
    end else if (i == MODDIS_IDX) begin : g_moddis
      assign rstVal = modDisIn;
    end else if (i == MEMCFG_IDX) begin : g_memcfg
      assign rstVal = MEMCFG_RST;
    end else begin : g_const
      assign rstVal = fixedResetOf(i);
    end

    always_comb begin
      case (RULE)
        ACC_RO:  nxt = q;
        ACC_W1C: nxt = q & ~busWdata;
        ACC_W1S: nxt = q | busWdata;
        default: nxt = busWdata;
      endcase
    end

    assign hit = stb.wr && (stb.idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (coldRst)  q <= rstVal;
      else if (hit) q <= nxt;
    end

    assign word[i] = q;
  end

  always_ff @(posedge clk) begin
    if (coldRst || warmRst) busRdata <= '0;
    else if (stb.rd)        busRdata <= word[stb.idx];
    else                    busRdata <= '0;
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DRAM_MB = 512
) (
  input  logic              clk,
  input  logic              coldRst,
  input  logic              warmRst,
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic              busErr,
  input  logic [31:0]       strapIn,
  input  logic [31:0]       modDisIn
);

  localparam bit DRAM_OK = (DRAM_MB >= 128) && (DRAM_MB <= 2048) &&
                           ((DRAM_MB & (DRAM_MB - 1)) == 0);

  if (!DRAM_OK) begin : g_badDram
    $error("DRAM_MB must be a power of two from 128 to 2048");
  end

  bankStrobeT stb;

  sysctl_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .coldRst   (coldRst),
    .warmRst   (warmRst),
    .busReq    (busReq),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .stb       (stb),
    .busReady  (busReady),
    .busErr    (busErr)
  );

  sysctl_dpath #(.DRAM_MB(DRAM_MB)) u_dpath (
    .clk      (clk),
    .coldRst  (coldRst),
    .warmRst  (warmRst),
    .stb      (stb),
    .busWdata (busWdata),
    .strapIn  (strapIn),
    .modDisIn (modDisIn),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              coldRst,
  input logic              warmRst,
  input logic              busReq,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busByteEn,
  input logic [31:0]       busRdata,
  input logic              busReady,
  input logic              busErr
);

  assert_ready_after_req_R10: assert property (@(posedge clk) disable iff (coldRst)
    (busReq && !warmRst) |=> busReady);

  assert_no_spurious_ready_R10: assert property (@(posedge clk) disable iff (coldRst)
    !(busReq && !warmRst) |=> !busReady);

  assert_misalign_err_R9: assert property (@(posedge clk) disable iff (coldRst)
    (busReq && !warmRst && busAddr[1:0] != 2'b00) |=> (busErr && busRdata == 32'h0));

  assert_partial_err_R9: assert property (@(posedge clk) disable iff (coldRst)
    (busReq && !warmRst && busByteEn != 4'hF) |=> (busErr && busRdata == 32'h0));

  assert_beyond_err_R8: assert property (@(posedge clk) disable iff (coldRst)
    (busReq && !warmRst && busAddr >= ADDR_W'(12'h148)) |=> (busErr && busRdata == 32'h0));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (coldRst)
    !busReady |-> (busRdata == 32'h0));

  assert_id_const_R5: assert property (@(posedge clk) disable iff (coldRst)
    (busReq && !warmRst && !busWe && busAddr == '0 && busByteEn == 4'hF)
      |=> (busRdata == 32'h04A9_2750 && !busErr));

  assert_warm_drop_R11: assert property (@(posedge clk) disable iff (coldRst)
    warmRst |=> (!busReady && !busErr));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .coldRst   (coldRst),
  .warmRst   (warmRst),
  .busReq    (busReq),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .busByteEn (busByteEn),
  .busRdata  (busRdata),
  .busReady  (busReady),
  .busErr    (busErr)
);

// File: tb/tb_sysctl_regbank.sv
module tb_sysctl_regbank;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        expErr;
    logic [7:0]  reqId;
  } vecT;

  localparam int NVEC = 39;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h04A92750, 1'b0, 8'd1},  // R1
    '{1'b0, 12'h004, 4'hF, 32'h0,         32'hA5A50F0F, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h07C, 4'hF, 32'h0,         32'h00000300, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h09C, 4'hF, 32'h0,         32'h00001202, 1'b0, 8'd3},  // R3
    '{1'b0, 12'h014, 4'hF, 32'h0,         32'h0000FFFF, 1'b0, 8'd1},
    '{1'b0, 12'h060, 4'hF, 32'h0,         32'h00080000, 1'b0, 8'd1},
    '{1'b0, 12'h144, 4'hF, 32'h0,         32'h034730E4, 1'b0, 8'd1},
    '{1'b0, 12'h13C, 4'hF, 32'h0,         32'h00000008, 1'b0, 8'd1},
    '{1'b0, 12'h008, 4'hF, 32'h0,         32'h00000000, 1'b0, 8'd1},
    '{1'b1, 12'h008, 4'hF, 32'hDEADBEEF,  32'h00000000, 1'b0, 8'd4},  // R4, R12
    '{1'b0, 12'h008, 4'hF, 32'h0,         32'hDEADBEEF, 1'b0, 8'd4},
    '{1'b1, 12'h000, 4'hF, 32'hFFFFFFFF,  32'h00000000, 1'b0, 8'd5},  // R5
    '{1'b0, 12'h000, 4'hF, 32'h0,         32'h04A92750, 1'b0, 8'd5},
    '{1'b1, 12'h004, 4'hF, 32'h00000000,  32'h00000000, 1'b0, 8'd5},
    '{1'b0, 12'h004, 4'hF, 32'h0,         32'hA5A50F0F, 1'b0, 8'd5},
    '{1'b1, 12'h040, 4'hF, 32'hFFFFFFFF,  32'h00000000, 1'b0, 8'd5},
    '{1'b0, 12'h040, 4'hF, 32'h0,         32'h00000000, 1'b0, 8'd5},
    '{1'b1, 12'h06C, 4'hF, 32'h00000001,  32'h00000000, 1'b0, 8'd6},  // R6
    '{1'b0, 12'h06C, 4'hF, 32'h0,         32'h80000000, 1'b0, 8'd6},
    '{1'b1, 12'h06C, 4'hF, 32'h80000000,  32'h00000000, 1'b0, 8'd6},
    '{1'b0, 12'h06C, 4'hF, 32'h0,         32'h00000000, 1'b0, 8'd6},
    '{1'b1, 12'h070, 4'hF, 32'h00000011,  32'h00000000, 1'b0, 8'd7},  // R7
    '{1'b1, 12'h070, 4'hF, 32'h00000100,  32'h00000000, 1'b0, 8'd7},
    '{1'b0, 12'h070, 4'hF, 32'h0,         32'h00000111, 1'b0, 8'd7},
    '{1'b1, 12'h070, 4'hF, 32'h00000000,  32'h00000000, 1'b0, 8'd7},
    '{1'b0, 12'h070, 4'hF, 32'h0,         32'h00000111, 1'b0, 8'd7},
    '{1'b1, 12'h07C, 4'hF, 32'h00000001,  32'h00000000, 1'b0, 8'd7},
    '{1'b0, 12'h07C, 4'hF, 32'h0,         32'h00000301, 1'b0, 8'd7},
    '{1'b0, 12'h148, 4'hF, 32'h0,         32'h00000000, 1'b1, 8'd8},  // R8
    '{1'b1, 12'h148, 4'hF, 32'hFFFFFFFF,  32'h00000000, 1'b1, 8'd8},
    '{1'b0, 12'hFFC, 4'hF, 32'h0,         32'h00000000, 1'b1, 8'd8},
    '{1'b1, 12'h009, 4'hF, 32'h12345678,  32'h00000000, 1'b1, 8'd9},  // R9
    '{1'b1, 12'h008, 4'h3, 32'h12345678,  32'h00000000, 1'b1, 8'd9},
    '{1'b0, 12'h002, 4'hF, 32'h0,         32'h00000000, 1'b1, 8'd9},
    '{1'b0, 12'h008, 4'hF, 32'h0,         32'hDEADBEEF, 1'b0, 8'd9},
    '{1'b1, 12'h0D4, 4'hF, 32'hFFFFFFFF,  32'h00000000, 1'b0, 8'd6},
    '{1'b0, 12'h0D4, 4'hF, 32'h0,         32'h00000000, 1'b0, 8'd6},
    '{1'b1, 12'h144, 4'hF, 32'h00000000,  32'h00000000, 1'b0, 8'd4},
    '{1'b0, 12'h144, 4'hF, 32'h0,         32'h00000000, 1'b0, 8'd4}
  };

  logic        clk = 1'b0;
  logic        coldRst = 1'b1;
  logic        warmRst = 1'b0;
  logic        busReq = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [3:0]  busByteEn = 4'hF;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic        busErr;
  logic [31:0] strapIn = 32'hA5A5_0F0F;
  logic [31:0] modDisIn = 32'h0000_0300;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  sysctl_regbank dut (
    .clk       (clk),
    .coldRst   (coldRst),
    .warmRst   (warmRst),
    .busReq    (busReq),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .busReady  (busReady),
    .busErr    (busErr),
    .strapIn   (strapIn),
    .modDisIn  (modDisIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample the response at the next one
  task automatic access(input logic we, input logic [11:0] addr, input logic [3:0] be,
                        input logic [31:0] wd);
    busReq    = 1'b1;
    busWe     = we;
    busAddr   = addr;
    busByteEn = be;
    busWdata  = wd;
    @(negedge clk);
    busReq    = 1'b0;
    busWe     = 1'b0;
    busByteEn = 4'hF;
  endtask

  task automatic readChk(input string tag, input logic [11:0] addr, input logic [31:0] exp);
    access(1'b0, addr, 4'hF, 32'h0);
    chk(tag, busRdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    coldRst = 1'b0;
    @(negedge clk);
    chk("R10 idle ready after reset", {31'h0, busReady}, 32'h0);
    chk("R12 idle rdata after reset", busRdata, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      access(VECS[k].we, VECS[k].addr, VECS[k].be, VECS[k].wd);
      chk($sformatf("R%0d vec%0d rdata", VECS[k].reqId, k), busRdata, VECS[k].exp);
      chk($sformatf("R%0d vec%0d err", VECS[k].reqId, k), {31'h0, busErr}, {31'h0, VECS[k].expErr});
      chk($sformatf("R10 vec%0d ready", k), {31'h0, busReady}, 32'h1);
    end

    // idle cycle: no ready, no data (R10, R12)
    @(negedge clk);
    chk("R10 no ready when idle", {31'h0, busReady}, 32'h0);
    chk("R12 rdata zero when idle", busRdata, 32'h0);

    // warm reset: request dropped, contents kept (R11)
    warmRst = 1'b1;
    access(1'b1, 12'h008, 4'hF, 32'h0000_0000);
    chk("R11 no ready under warm reset", {31'h0, busReady}, 32'h0);
    @(negedge clk);
    warmRst = 1'b0;
    readChk("R11 rw word kept", 12'h008, 32'hDEADBEEF);
    readChk("R11 w1s word kept", 12'h070, 32'h0000_0111);

    // cold reset with new straps reloads the image (R1, R2, R3)
    strapIn  = 32'h1234_5678;
    modDisIn = 32'h0000_000F;
    coldRst  = 1'b1;
    repeat (3) @(negedge clk);
    coldRst = 1'b0;
    @(negedge clk);
    chk("R10 ready low after cold reset", {31'h0, busReady}, 32'h0);
    readChk("R2 strap reload", 12'h004, 32'h1234_5678);
    readChk("R2 module-disable reload", 12'h07C, 32'h0000_000F);
    readChk("R1 rw word cleared", 12'h008, 32'h0);
    readChk("R1 w1s word cleared", 12'h070, 32'h0);
    readChk("R1 w1c word restored", 12'h06C, 32'h8000_0000);
    readChk("R1 word 0x144 restored", 12'h144, 32'h0347_30E4);
    readChk("R3 memory config", 12'h09C, 32'h0000_1202);

    summary();
  end

endmodule